// File: doc/BRIEF.md
# Display Core Clock Retune Sequencer

This block moves the core clock of a display engine to a new target frequency. A caller gives a one-cycle request with the target in kHz. The block checks the target against a small set of supported operating points. For a supported target it tells the power controller, through a mailbox handshake, that a change is coming. It then switches the clock PLL off and on where the operating point needs it, and waits for lock. It writes the divider, precharge and frequency fields of a clock-control register. Last, it sends the new frequency to the power controller.

The PLL and the mailbox firmware sit outside the block. The block only drives their control lines and reads their status. A lock wait that runs past a parameterised number of cycles raises a sticky error, and the sequence still goes on. The frequency last confirmed by the power controller is kept and shown on an output. A one-cycle done pulse ends every request, including the ones that are rejected or aborted.

Top module: `dclk_retune_seq`

## Requirements
- R1: The supported targets and their settings are:
  - 144000 kHz: ratio 60, divider code 3 (/4).
  - 288000 kHz: ratio 60, divider code 2 (/2).
  - 384000 kHz: ratio 60, divider code 1 (/1.5).
  - 576000 kHz: ratio 60, divider code 0 (/1).
  - 624000 kHz: ratio 65, divider code 0 (/1).
  - 19200 kHz: bypass, with the PLL left off.
- R2: Any other target is rejected. The block raises err and pulses done, and issues no mailbox transaction. It changes no register, no PLL setting and the stored frequency.
- R3: Every accepted request first does a mailbox write with command 0x17 and data 0x80000000. If that write returns an error, the block raises err, pulses done and changes nothing else.
- R4: The PLL enable is driven low before programming when any of these holds:
  - The target is 19200.
  - The target is 624000.
  - The present frequency is 624000. The present frequency is decoded from clk_ctl[10:0] as field*500+1000 kHz.
  
  In every other case a running PLL stays enabled throughout.
- R5: After the PLL is disabled, the block waits for pll_lock to fall. After it is enabled, the block waits for pll_lock to rise. Each wait gives up after TIMEOUT_CYC cycles. A timeout raises err, and the sequence continues.
- R6: For a non-bypass target, only pll_ctl[7:0] (the ratio) is replaced. Bits 31:8 keep their value. pll_en is then set to 1.
- R7: For a non-bypass target, clk_ctl is written as follows, and every other bit keeps its value:
  - [23:22] takes the divider code.
  - [16] is set to 1 exactly when the target is at least 500000 kHz.
  - [10:0] takes (target-1000)/500.
  
  A bypass target leaves clk_ctl unchanged.
- R8: The last mailbox write carries command 0x17 and data ceil(target/25000). cur_khz takes the target only if this write returns no error. Otherwise err is raised.
- R9: busy is high from the cycle after acceptance until done. done is high for exactly one cycle. A request that arrives while busy is ignored.
- R10: err is cleared when a new request is accepted. It then stays at its final value after done, until the next accepted request.
- R11: After reset the outputs are as follows:
  - busy, done, err, mbx_req and pll_en are 0.
  - pll_ctl is PLLCTL_RST and clk_ctl is CLKCTL_RST.
  - cur_khz is the value decoded from CLKCTL_RST[10:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle change request |
| req_khz | input | 20 | Target frequency in kHz |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Sticky error for the last request |
| cur_khz | output | 20 | Last frequency confirmed by the power controller |
| mbx_req | output | 1 | Mailbox write request, held until acknowledged |
| mbx_cmd | output | 8 | Mailbox command |
| mbx_data | output | 32 | Mailbox write data |
| mbx_ack | input | 1 | Mailbox acknowledge pulse |
| mbx_err | input | 1 | Mailbox error, valid with mbx_ack |
| pll_en | output | 1 | PLL enable |
| pll_ctl | output | 32 | PLL control register, ratio in [7:0] |
| pll_lock | input | 1 | PLL lock status |
| clk_ctl | output | 32 | Clock-control register |

## Verification
A corrupted clk_ctl frequency field shows up on the next request. The PLL would be switched off when it should not be, or left running when it should be switched off, and pll_en shows which within a few cycles of acceptance. A wrong latched target or a wrong table entry shows up at done. It appears as a wrong ratio, divider, precharge bit or field, or a wrong second mailbox word. A mis-sequenced state shows up sooner: the mailbox traffic has the wrong length, or done and busy overlap. A lost timeout shows up as err missing at done.

// File: rtl/dclk_pkg.sv
package dclk_pkg;
    localparam int KHZ_W   = 20;
    localparam int FIELD_W = 11;
    localparam int RATIO_W = 8;
    localparam int DIV_W   = 2;
    localparam int UNIT_W  = 8;

    localparam int unsigned BYPASS_KHZ  = 19200;
    localparam int unsigned TOGGLE_KHZ  = 624000;
    localparam int unsigned PRE_MIN_KHZ = 500000;

    localparam logic [7:0]  MBX_CMD_FREQ = 8'h17;
    localparam logic [31:0] MBX_PREPARE  = 32'h8000_0000;

    // clock-control field positions (decoded by the clock divider)
    localparam int DIV_LSB = 22;
    localparam int PRE_BIT = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NOTE_PRE,
        ST_PLL_OFF,
        ST_PLL_SET,
        ST_PLL_LOCK,
        ST_CTL_WR,
        ST_NOTE_POST
    } dclk_state_e;

    typedef struct packed {
        logic               valid;
        logic               bypass;
        logic [RATIO_W-1:0] ratio;
        logic [DIV_W-1:0]   div;
        logic               pre;
        logic [FIELD_W-1:0] field;
        logic [UNIT_W-1:0]  units;
    } dclk_entry_t;
endpackage

// File: rtl/dclk_freq_map.sv
module dclk_freq_map
    import dclk_pkg::*;
(
    input  logic [KHZ_W-1:0] khz_i,
    output dclk_entry_t      ent_o
);
    always_comb begin
        ent_o       = '0;
        ent_o.valid = 1'b1;
        ent_o.pre   = (khz_i >= KHZ_W'(PRE_MIN_KHZ));
        case (khz_i)
            KHZ_W'(144000): begin
                ent_o.ratio = 8'd60; ent_o.div = 2'd3; ent_o.field = 11'd286;  ent_o.units = 8'd6;
            end
            KHZ_W'(288000): begin
                ent_o.ratio = 8'd60; ent_o.div = 2'd2; ent_o.field = 11'd574;  ent_o.units = 8'd12;
            end
            KHZ_W'(384000): begin
                ent_o.ratio = 8'd60; ent_o.div = 2'd1; ent_o.field = 11'd766;  ent_o.units = 8'd16;
            end
            KHZ_W'(576000): begin
                ent_o.ratio = 8'd60; ent_o.div = 2'd0; ent_o.field = 11'd1150; ent_o.units = 8'd24;
            end
            KHZ_W'(TOGGLE_KHZ): begin
                ent_o.ratio = 8'd65; ent_o.div = 2'd0; ent_o.field = 11'd1246; ent_o.units = 8'd25;
            end
            KHZ_W'(BYPASS_KHZ): begin
                ent_o.bypass = 1'b1; ent_o.units = 8'd1;
            end
            default: ent_o.valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/dclk_wait_timer.sv
module dclk_wait_timer #(
    parameter int unsigned LIMIT = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run_i)                  cnt_d = '0;
        else if (cnt_q != CW'(LIMIT)) cnt_d = cnt_q + CW'(1);
        else                         cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == CW'(LIMIT));

    assert_timer_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !expired_o);
endmodule

// File: rtl/dclk_retune_seq.sv
module dclk_retune_seq
    import dclk_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 200,
    parameter logic [31:0] PLLCTL_RST  = 32'h5A00_003C,
    parameter logic [31:0] CLKCTL_RST  = 32'h4080_023E
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [KHZ_W-1:0] req_khz,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [KHZ_W-1:0] cur_khz,
    output logic             mbx_req,
    output logic [7:0]       mbx_cmd,
    output logic [31:0]      mbx_data,
    input  logic             mbx_ack,
    input  logic             mbx_err,
    output logic             pll_en,
    output logic [31:0]      pll_ctl,
    input  logic             pll_lock,
    output logic [31:0]      clk_ctl
);
    localparam int unsigned RST_KHZ = 32'(CLKCTL_RST[FIELD_W-1:0]) * 500 + 1000;

    typedef struct packed {
        dclk_state_e      state;
        logic [KHZ_W-1:0] khz;
        dclk_entry_t      ent;
        logic             pll_en;
        logic [31:0]      pll_ctl;
        logic [31:0]      clkctl;
        logic [KHZ_W-1:0] cur;
        logic             err;
        logic             done;
    } seq_regs_t;

    localparam seq_regs_t RST_REGS = '{
        state: ST_IDLE, khz: '0, ent: '0, pll_en: 1'b0,
        pll_ctl: PLLCTL_RST, clkctl: CLKCTL_RST,
        cur: KHZ_W'(RST_KHZ), err: 1'b0, done: 1'b0
    };

    seq_regs_t   d, q;
    dclk_entry_t map_ent;
    logic        tmr_run, tmr_exp, need_off;
    logic [KHZ_W-1:0] cur_dec;

    dclk_freq_map u_map (
        .khz_i (req_khz),
        .ent_o (map_ent)
    );

    assign tmr_run = (q.state == ST_PLL_OFF) || (q.state == ST_PLL_LOCK);

    dclk_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (tmr_run),
        .expired_o (tmr_exp)
    );

    // present frequency as held in the offset fixed-point field
    assign cur_dec  = KHZ_W'(q.clkctl[FIELD_W-1:0]) * KHZ_W'(500) + KHZ_W'(1000);
    assign need_off = q.ent.bypass || (q.khz == KHZ_W'(TOGGLE_KHZ)) ||
                      (cur_dec == KHZ_W'(TOGGLE_KHZ));

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.khz = req_khz;
                    d.ent = map_ent;
                    d.err = !map_ent.valid;
                    if (map_ent.valid) d.state = ST_NOTE_PRE;
                    else               d.done  = 1'b1;
                end
            end
            ST_NOTE_PRE: begin
                if (mbx_ack) begin
                    if (mbx_err) begin
                        d.err   = 1'b1;
                        d.done  = 1'b1;
                        d.state = ST_IDLE;
                    end else if (need_off) begin
                        d.pll_en = 1'b0;
                        d.state  = ST_PLL_OFF;
                    end else begin
                        d.state = q.ent.bypass ? ST_NOTE_POST : ST_PLL_SET;
                    end
                end
            end
            ST_PLL_OFF: begin
                if (!pll_lock || tmr_exp) begin
                    if (pll_lock) d.err = 1'b1;
                    d.state = q.ent.bypass ? ST_NOTE_POST : ST_PLL_SET;
                end
            end
            ST_PLL_SET: begin
                d.pll_ctl[RATIO_W-1:0] = q.ent.ratio;
                d.pll_en               = 1'b1;
                d.state                = ST_PLL_LOCK;
            end
            ST_PLL_LOCK: begin
                if (pll_lock || tmr_exp) begin
                    if (!pll_lock) d.err = 1'b1;
                    d.state = ST_CTL_WR;
                end
            end
            ST_CTL_WR: begin
                d.clkctl[DIV_LSB +: DIV_W]  = q.ent.div;
                d.clkctl[PRE_BIT]           = q.ent.pre;
                d.clkctl[FIELD_W-1:0]       = q.ent.field;
                d.state                     = ST_NOTE_POST;
            end
            ST_NOTE_POST: begin
                if (mbx_ack) begin
                    if (mbx_err) d.err = 1'b1;
                    else         d.cur = q.khz;
                    d.done  = 1'b1;
                    d.state = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_REGS;
        else        q <= d;
    end

    assign busy     = (q.state != ST_IDLE);
    assign done     = q.done;
    assign err      = q.err;
    assign cur_khz  = q.cur;
    assign pll_en   = q.pll_en;
    assign pll_ctl  = q.pll_ctl;
    assign clk_ctl  = q.clkctl;
    assign mbx_req  = (q.state == ST_NOTE_PRE) || (q.state == ST_NOTE_POST);
    assign mbx_cmd  = mbx_req ? MBX_CMD_FREQ : 8'h00;
    assign mbx_data = (q.state == ST_NOTE_PRE)  ? MBX_PREPARE :
                      (q.state == ST_NOTE_POST) ? 32'(q.ent.units) : 32'h0;

    assert_mbx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mbx_req && !mbx_ack |=> mbx_req && $stable(mbx_data));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_supported_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> q.ent.valid);

    assert_ratio_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(pll_ctl[31:RATIO_W]));

    assert_ctl_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $stable({clk_ctl[31:24], clk_ctl[21:17], clk_ctl[15:FIELD_W]}));

    assert_precharge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clk_ctl[PRE_BIT] == (cur_dec >= KHZ_W'(PRE_MIN_KHZ)));

    assert_cur_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_khz) |-> done);

    assert_pll_rise_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_en) |-> busy);
endmodule

// File: tb/dclk_retune_seq_bench.sv
module dclk_retune_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_khz = '0;
    logic        busy, done, err;
    logic [19:0] cur_khz;
    logic        mbx_req;
    logic [7:0]  mbx_cmd;
    logic [31:0] mbx_data;
    logic        mbx_ack = 1'b0, mbx_err = 1'b0;
    logic        pll_en;
    logic [31:0] pll_ctl, clk_ctl;
    logic        pll_lock = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dclk_retune_seq u_dclk_retune_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_khz(req_khz),
        .busy(busy), .done(done), .err(err), .cur_khz(cur_khz),
        .mbx_req(mbx_req), .mbx_cmd(mbx_cmd), .mbx_data(mbx_data),
        .mbx_ack(mbx_ack), .mbx_err(mbx_err),
        .pll_en(pll_en), .pll_ctl(pll_ctl), .pll_lock(pll_lock), .clk_ctl(clk_ctl)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    typedef struct {
        int          khz;
        bit          err;
        logic [19:0] cur;
        logic [31:0] clkctl;
        logic [31:0] pllctl;
        bit          pllen;
        bit          sawlow;
        int          nmbx;
        logic [31:0] data2;
    } exp_t;

    exp_t sb_q[$];

    // knobs and observations
    bit k_err1 = 0, k_err2 = 0, k_stuck = 0, k_nolock = 0;
    int mb_n = 0, mb_wait = 0;
    logic [31:0] mb_data2 = '0;
    bit saw_low = 0;

    // model state
    logic [19:0] m_cur    = 20'd288000;
    logic [31:0] m_clk    = 32'h4080_023E;
    logic [31:0] m_pll    = 32'h5A00_003C;
    bit          m_pllon  = 0;

    // mailbox responder: acknowledges on the second cycle of a request
    initial begin
        forever begin
            @(negedge clk);
            mbx_ack = 1'b0;
            mbx_err = 1'b0;
            if (rst_n && mbx_req) begin
                mb_wait++;
                if (mb_wait == 2) begin
                    mb_wait = 0;
                    mbx_ack = 1'b1;
                    chk(mbx_cmd == 8'h17, "R3 mailbox command", 32'(mbx_cmd), 32'h17);
                    if (mb_n == 0) begin
                        mbx_err = k_err1;
                        chk(mbx_data == 32'h8000_0000, "R3 first mailbox data", mbx_data, 32'h8000_0000);
                    end else begin
                        mbx_err  = k_err2;
                        mb_data2 = mbx_data;
                    end
                    mb_n++;
                end
            end
        end
    end

    // PLL model: lock follows enable three cycles later unless a knob overrides
    initial begin
        logic [2:0] sh = '0;
        forever begin
            @(negedge clk);
            sh = {sh[1:0], pll_en};
            if (!rst_n)        pll_lock = 1'b0;
            else if (k_stuck)  pll_lock = 1'b1;
            else if (k_nolock) pll_lock = 1'b0;
            else               pll_lock = sh[2];
            if (busy && !pll_en) saw_low = 1'b1;
        end
    end

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected done", 32'h1, 32'h0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(err == e.err, $sformatf("R5 R8 err for %0d", e.khz), 32'(err), 32'(e.err));
                    chk(cur_khz == e.cur, $sformatf("R8 cur_khz for %0d", e.khz), 32'(cur_khz), 32'(e.cur));
                    chk(clk_ctl == e.clkctl, $sformatf("R1 R7 clk_ctl for %0d", e.khz), clk_ctl, e.clkctl);
                    chk(pll_ctl == e.pllctl, $sformatf("R1 R6 pll_ctl for %0d", e.khz), pll_ctl, e.pllctl);
                    chk(pll_en == e.pllen, $sformatf("R6 pll_en for %0d", e.khz), 32'(pll_en), 32'(e.pllen));
                    chk(saw_low == e.sawlow, $sformatf("R4 pll disable for %0d", e.khz), 32'(saw_low), 32'(e.sawlow));
                    chk(mb_n == e.nmbx, $sformatf("R2 R3 mailbox count for %0d", e.khz), 32'(mb_n), 32'(e.nmbx));
                    if (e.nmbx == 2)
                        chk(mb_data2 == e.data2, $sformatf("R8 final mailbox data for %0d", e.khz), mb_data2, e.data2);
                    chk(!busy, "R9 busy low at done", 32'(busy), 32'h0);
                    @(negedge clk);
                    chk(!done, "R9 done one cycle", 32'(done), 32'h0);
                    chk(err == e.err, "R10 err held after done", 32'(err), 32'(e.err));
                end
            end
        end
    end

    task automatic run_req(input int khz, input bit e1, input bit e2,
                           input bit stuck, input bit nolock, input int stray);
        exp_t e;
        bit ok, byp, tog;
        logic [7:0] ratio;
        logic [1:0] dv;
        ok = 1; byp = 0; ratio = 8'd60; dv = 2'd0;
        case (khz)
            144000: dv = 2'd3;
            288000: dv = 2'd2;
            384000: dv = 2'd1;
            576000: dv = 2'd0;
            624000: ratio = 8'd65;
            19200:  byp = 1;
            default: ok = 0;
        endcase
        e.khz = khz; e.data2 = '0;
        if (!ok) begin
            e.err = 1; e.nmbx = 0; e.sawlow = 0;
        end else if (e1) begin
            e.err = 1; e.nmbx = 1; e.sawlow = !m_pllon;
        end else begin
            tog = byp || khz == 624000 || (int'(m_clk[10:0]) * 500 + 1000) == 624000;
            e.err = tog && stuck;
            e.sawlow = tog || !m_pllon;
            if (!byp) begin
                m_pll[7:0]   = ratio;
                m_pllon      = 1;
                if (nolock) e.err = 1;
                m_clk[23:22] = dv;
                m_clk[16]    = (khz >= 500000);
                m_clk[10:0]  = 11'((khz - 1000) / 500);
            end else begin
                m_pllon = 0;
            end
            e.nmbx  = 2;
            e.data2 = 32'((khz + 24999) / 25000);
            if (e2) e.err = 1;
            else    m_cur = 20'(khz);
        end
        e.cur = m_cur; e.clkctl = m_clk; e.pllctl = m_pll; e.pllen = m_pllon;
        k_err1 = e1; k_err2 = e2; k_stuck = stuck; k_nolock = nolock;
        mb_n = 0; mb_wait = 0; saw_low = 0;
        sb_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_khz = 20'(khz);
        @(negedge clk);
        req_valid = 1'b0;
        if (ok) chk(busy, "R9 busy after accept", 32'(busy), 32'h1);
        if (stray != 0) begin
            repeat (2) @(negedge clk);
            chk(busy, "R9 busy before stray request", 32'(busy), 32'h1);
            req_valid = 1'b1; req_khz = 20'(stray);
            @(negedge clk);
            req_valid = 1'b0;
        end
        wait (sb_q.size() == 0);
        repeat (3) @(negedge clk);
        k_err1 = 0; k_err2 = 0; k_stuck = 0; k_nolock = 0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog expired", 32'h0, 32'h1);
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err, "R11 status after reset", {29'd0, busy, done, err}, 32'h0);
        chk(cur_khz == 20'd288000, "R11 cur_khz after reset", 32'(cur_khz), 32'd288000);
        chk(clk_ctl == 32'h4080_023E, "R11 clk_ctl after reset", clk_ctl, 32'h4080_023E);
        chk(pll_ctl == 32'h5A00_003C, "R11 pll_ctl after reset", pll_ctl, 32'h5A00_003C);
        chk(!pll_en && !mbx_req, "R11 pll_en mbx_req after reset", {30'd0, pll_en, mbx_req}, 32'h0);

        run_req(288000, 0, 0, 0, 0, 0);   // R1 start from PLL off
        run_req(144000, 0, 0, 0, 0, 0);   // R1 no toggle
        run_req(384000, 0, 0, 0, 0, 0);   // R1 divider 1.5
        run_req(576000, 0, 0, 0, 0, 0);   // R7 precharge set
        run_req(624000, 0, 0, 0, 0, 0);   // R4 toggle by target
        run_req(576000, 0, 0, 0, 0, 0);   // R4 toggle by present frequency
        run_req(12345,  0, 0, 0, 0, 0);   // R2 unsupported
        run_req(19200,  0, 0, 0, 0, 0);   // R4 R7 bypass
        run_req(144000, 0, 0, 0, 0, 0);   // R6 restart from bypass
        run_req(288000, 1, 0, 0, 0, 0);   // R3 first notification error
        run_req(384000, 0, 1, 0, 0, 0);   // R8 final notification error
        run_req(624000, 0, 0, 1, 0, 0);   // R5 unlock timeout
        run_req(576000, 0, 0, 0, 1, 0);   // R5 lock timeout
        run_req(288000, 0, 0, 0, 0, 144000); // R9 request while busy
        chk(!busy, "R9 stray request not started", 32'(busy), 32'h0);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule